// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises data words onto a single asynchronous line. A word written through the write port first lands in a one-entry holding buffer. Whenever the shift stage is empty, the word moves on at once and a one-cycle buffer-free interrupt pulse tells the producer that the next word may be written. Because of this, one word can wait in the holding buffer while the previous one is still on the line.

Frames begin only on a baud tick, which is the overflow of an external divide-by-16 baud timer. A frame also needs the run enable to be set. Each baud tick marks one bit time. A frame is a low start bit, then a data field sent least significant bit first, then one or two high stop bits. The field is eight or nine bits wide. The ninth bit can carry data, a wake-up flag supplied by the writer, or a computed parity bit.

When a word is waiting as the last stop bit ends, the next start bit goes out on that same tick, so there is no idle bit between frames. A write to a full holding buffer replaces its contents and sets a sticky overrun flag.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, `txd` is 1 and `tx_busy`, `buf_irq` and `ovr_flag` are all 0.
- R2: A frame is one 0 start bit, then the data field sent least significant bit first, then stop bits at 1. There is one stop bit when `cfg_two_stop` is 0 and two when it is 1. Each bit lasts from one baud tick to the next.
- R3: The field layout follows `cfg_fmt`. Code 0 sends 8 data bits `wr_data[7:0]`. Code 1 sends 7 data bits `wr_data[6:0]` followed by a parity bit. Code 2 sends 9 data bits `wr_data[8:0]`, with bit 8 used as a data or wake-up bit. Code 3 sends 8 data bits `wr_data[7:0]` followed by a parity bit as the ninth bit.
- R4: When `cfg_odd` is 0, the parity bit makes the number of ones across the data bits and the parity bit even. When `cfg_odd` is 1, it makes that number odd.
- R5: Suppose the shift stage is empty and a write is sampled at clock edge k. Then `buf_irq` is 1 for exactly the cycle after edge k+1, and `tx_busy` is 1 from that point on.
- R6: A pending frame does not leave the idle level until a baud tick arrives. `txd` changes only at an edge where `baud_tick` or a cleared `run_en` was sampled.
- R7: A word written while a frame is shifting waits in the holding buffer. At the tick that ends the last stop bit, the word moves into the shift stage, `buf_irq` pulses, and its start bit goes out at that same edge with no idle bit.
- R8: While `run_en` is 0, `txd` is 1 and no frame starts. A pending frame goes out after `run_en` returns to 1.
- R9: A write to a full holding buffer that is not being emptied in the same cycle replaces the buffered word, so the old word is never sent. Such a write also sets `ovr_flag`. The flag stays set until `ovr_clr` is pulsed.
- R10: After the last stop bit ends with the holding buffer empty, `tx_busy` returns to 0 and `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send; bit 8 is used in code 2 only |
| cfg_fmt | input | 2 | Field layout code (see R3) |
| cfg_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| run_en | input | 1 | Transmitter run enable |
| baud_tick | input | 1 | One-cycle pulse per bit time from the divide-by-16 baud timer |
| ovr_clr | input | 1 | Clears the overrun flag |
| txd | output | 1 | Serial output, idle high |
| buf_irq | output | 1 | One-cycle pulse when the holding buffer empties into the shift stage |
| tx_busy | output | 1 | The shift stage holds a frame, either pending or being sent |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
Two functions can fall on the same clock edge. One is the tick that ends the last stop bit of one frame. The other is both moving the waiting word into the shift stage and starting that word's frame.

The bench provokes this by writing a second and third word while the first frame is still being sent. It then checks that `txd` already shows the new start bit in the cycle where `buf_irq` pulses. The scoreboard monitor counts idle bit times between frames and fails any back-to-back frame that is preceded by one.

// File: rtl/utx_pkg.sv
package utx_pkg;
   typedef enum logic [1:0] {
      FMT_PLAIN     = 2'd0,
      FMT_PLAIN_PAR = 2'd1,
      FMT_WIDE      = 2'd2,
      FMT_WIDE_PAR  = 2'd3
   } utx_fmt_e;
endpackage

// File: rtl/utx_hold_buf.sv
module utx_hold_buf #(
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   input  logic              ovr_clr,
   output logic              hold_full,
   output logic [WORD_W-1:0] hold_data,
   output logic              ovr_flag
);
   // Buffer loaded but not emptied in this cycle: a write now is an overrun.
   logic clobber;
   assign clobber = wr_en && hold_full && !take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
         ovr_flag  <= 1'b0;
      end else begin
         if (wr_en) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
         end else if (take) begin
            hold_full <= 1'b0;
         end
         if (clobber)
            ovr_flag <= 1'b1;
         else if (ovr_clr)
            ovr_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/utx_frame_build.sv
module utx_frame_build
   import utx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit PARITY_EN = 1'b1,
   localparam int WORD_W   = DATA_W + 1,
   localparam int FRAME_W  = WORD_W + 3,
   localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
   input  logic [WORD_W-1:0]  word,
   input  utx_fmt_e           fmt,
   input  logic               odd,
   input  logic               two_stop,
   output logic [FRAME_W-1:0] frame,
   output logic [LEN_W-1:0]   len
);
   int          fw;
   logic        wide;
   logic        par_on;
   logic        par_bit;
   logic [WORD_W-1:0] field;

   assign wide   = (fmt == FMT_WIDE) || (fmt == FMT_WIDE_PAR);
   assign par_on = (fmt == FMT_PLAIN_PAR) || (fmt == FMT_WIDE_PAR);
   assign fw     = wide ? WORD_W : DATA_W;

   generate
      if (PARITY_EN) begin : g_par
         always_comb begin
            par_bit = odd;
            for (int i = 0; i < WORD_W; i++)
               if (i < fw - 1) par_bit = par_bit ^ word[i];
         end
      end else begin : g_nopar
         assign par_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      field = '0;
      for (int i = 0; i < WORD_W; i++)
         if (i < fw) field[i] = word[i];
      if (par_on && PARITY_EN)
         field[fw-1] = par_bit;
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < WORD_W; i++)
         if (i < fw) frame[i+1] = field[i];
      len = LEN_W'(1 + fw + (two_stop ? 2 : 1));
   end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
   parameter int FRAME_W = 12,
   parameter int LEN_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               baud_tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame_in,
   input  logic [LEN_W-1:0]   len_in,
   output logic               txd,
   output logic               loaded,
   output logic               end_tick
);
   logic [FRAME_W-1:0] sh_buf;
   logic [LEN_W-1:0]   sh_len;
   logic [FRAME_W-1:0] work;
   logic [LEN_W-1:0]   cnt;
   logic               active;
   logic               start_idle;

   assign end_tick   = active && run_en && baud_tick && (cnt == '0);
   assign start_idle = loaded && !active && run_en && baud_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_buf <= '1;
         sh_len <= '0;
         loaded <= 1'b0;
      end else if (load) begin
         sh_buf <= frame_in;
         sh_len <= len_in;
         loaded <= 1'b1;
      end else if (end_tick) begin
         loaded <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         txd    <= 1'b1;
         work   <= '1;
         cnt    <= '0;
      end else if (!run_en) begin
         active <= 1'b0;
         txd    <= 1'b1;
      end else if (end_tick) begin
         if (load) begin
            txd  <= frame_in[0];
            work <= {1'b1, frame_in[FRAME_W-1:1]};
            cnt  <= len_in - LEN_W'(1);
         end else begin
            active <= 1'b0;
            txd    <= 1'b1;
         end
      end else if (start_idle) begin
         active <= 1'b1;
         txd    <= sh_buf[0];
         work   <= {1'b1, sh_buf[FRAME_W-1:1]};
         cnt    <= sh_len - LEN_W'(1);
      end else if (active && baud_tick) begin
         txd  <= work[0];
         work <= {1'b1, work[FRAME_W-1:1]};
         cnt  <= cnt - LEN_W'(1);
      end
   end
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
   import utx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit PARITY_EN = 1'b1,
   localparam int WORD_W   = DATA_W + 1,
   localparam int FRAME_W  = WORD_W + 3,
   localparam int LEN_W    = $clog2(FRAME_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [1:0]        cfg_fmt,
   input  logic              cfg_odd,
   input  logic              cfg_two_stop,
   input  logic              run_en,
   input  logic              baud_tick,
   input  logic              ovr_clr,
   output logic              txd,
   output logic              buf_irq,
   output logic              tx_busy,
   output logic              ovr_flag
);
   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
         $error("uart_dbuf_tx: DATA_W must lie in 5..16");
      end
   endgenerate

   logic               hold_full;
   logic [WORD_W-1:0]  hold_data;
   logic               take;
   logic               loaded;
   logic               end_tick;
   logic [FRAME_W-1:0] frame;
   logic [LEN_W-1:0]   len;
   logic               irq_q;

   assign take = hold_full && (!loaded || end_tick);

   utx_hold_buf #(.WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .take(take), .ovr_clr(ovr_clr), .hold_full(hold_full),
      .hold_data(hold_data), .ovr_flag(ovr_flag)
   );

   utx_frame_build #(.DATA_W(DATA_W), .PARITY_EN(PARITY_EN)) u_build (
      .word(hold_data), .fmt(utx_fmt_e'(cfg_fmt)), .odd(cfg_odd),
      .two_stop(cfg_two_stop), .frame(frame), .len(len)
   );

   utx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .baud_tick(baud_tick),
      .load(take), .frame_in(frame), .len_in(len), .txd(txd),
      .loaded(loaded), .end_tick(end_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= take;
   end

   assign buf_irq = irq_q;
   assign tx_busy = loaded;
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic baud_tick,
   input logic wr_en,
   input logic ovr_clr,
   input logic txd,
   input logic buf_irq,
   input logic tx_busy,
   input logic ovr_flag
);
   p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> txd);

   p_line_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> ($past(baud_tick) || !$past(run_en)));

   p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq |=> !buf_irq);

   p_irq_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_irq |-> tx_busy);

   p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $past(wr_en));

   p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_clr && !wr_en) |=> !ovr_flag);
endmodule

bind uart_dbuf_tx utx_checker u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .baud_tick(baud_tick),
   .wr_en(wr_en), .ovr_clr(ovr_clr), .txd(txd), .buf_irq(buf_irq),
   .tx_busy(tx_busy), .ovr_flag(ovr_flag)
);

// File: tb/tb_uart_dbuf_tx.sv
module tb_uart_dbuf_tx;
   localparam int P = 6;

   typedef struct {
      logic [11:0] bits;
      int          len;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic [1:0] cfg_fmt = 2'd0;
   logic       cfg_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       run_en = 1'b1;
   logic       baud_tick = 1'b0;
   logic       ovr_clr = 1'b0;
   logic       txd, buf_irq, tx_busy, ovr_flag;

   int   checks = 0;
   int   fails = 0;
   bit   tick_en = 1'b0;
   int   tick_cnt = 0;
   logic tick_d = 1'b0;
   exp_t exp_q[$];
   bit   in_frame = 1'b0;
   bit   b2b_mode = 1'b0;
   int   idle_ticks = 0;
   int   bit_i = 0;
   bit   frame_bad = 1'b0;
   exp_t cur;

   uart_dbuf_tx dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cfg_fmt(cfg_fmt), .cfg_odd(cfg_odd), .cfg_two_stop(cfg_two_stop),
      .run_en(run_en), .baud_tick(baud_tick), .ovr_clr(ovr_clr),
      .txd(txd), .buf_irq(buf_irq), .tx_busy(tx_busy), .ovr_flag(ovr_flag)
   );

   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic exp_t make_exp(logic [8:0] w, int fmt, bit odd, bit two);
      exp_t e;
      int   nd;
      bit   p;
      nd = (fmt >= 2) ? 9 : 8;
      e.bits = '1;
      e.bits[0] = 1'b0;
      for (int k = 0; k < nd; k++) e.bits[1+k] = w[k];
      if (fmt == 1 || fmt == 3) begin
         p = odd;
         for (int k = 0; k < nd - 1; k++) p = p ^ w[k];
         e.bits[nd] = p;
      end
      e.len = 1 + nd + (two ? 2 : 1);
      return e;
   endfunction

   task automatic write_raw(input logic [8:0] w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic write(input logic [8:0] w);
      exp_q.push_back(make_exp(w, int'(cfg_fmt), cfg_odd, cfg_two_stop));
      write_raw(w);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (exp_q.size() != 0 || in_frame || tx_busy);
      repeat (2 * P) @(negedge clk);
   endtask

   // Baud tick generator
   initial forever begin
      @(negedge clk);
      if (tick_en) begin
         tick_cnt++;
         baud_tick = (tick_cnt % P == 0);
      end else begin
         baud_tick = 1'b0;
      end
   end

   always @(posedge clk) tick_d <= baud_tick;

   // Monitor: one sample per bit time, right after the tick edge
   always @(negedge clk) begin
      if (tick_d && rst_n) begin
         if (!in_frame) begin
            if (txd == 1'b0) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R2", "unexpected frame start", 0, 1);
               end else begin
                  cur = exp_q.pop_front();
                  in_frame = 1'b1;
                  bit_i = 1;
                  frame_bad = 1'b0;
                  if (b2b_mode)
                     check(idle_ticks == 0, "R7", "idle bits before back-to-back frame",
                           idle_ticks, 0);
               end
               idle_ticks = 0;
            end else begin
               idle_ticks++;
            end
         end else begin
            if (txd !== cur.bits[bit_i]) frame_bad = 1'b1;
            bit_i++;
            if (bit_i == cur.len) begin
               in_frame = 1'b0;
               check(!frame_bad, "R2 R3 R4", "frame bits", 0, int'(cur.bits));
            end
         end
      end
   end

   initial begin
      #750000;
      check(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(txd === 1'b1, "R1", "txd after reset", txd, 1);
      check(tx_busy === 1'b0 && buf_irq === 1'b0 && ovr_flag === 1'b0, "R1",
            "busy/irq/ovr after reset", {tx_busy, buf_irq, ovr_flag}, 0);

      // R5 immediate transfer, R6 hold until tick
      write(9'h0A5);
      @(negedge clk);
      check(buf_irq === 1'b1 && tx_busy === 1'b1, "R5", "irq and busy after move",
            {buf_irq, tx_busy}, 3);
      @(negedge clk);
      check(buf_irq === 1'b0, "R5", "irq single cycle", buf_irq, 0);
      begin
         bit stayed = 1'b1;
         repeat (20) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 1'b0;
         end
         check(stayed, "R6", "line idle before tick", 0, 1);
      end
      tick_en = 1'b1;
      wait_idle();
      check(tx_busy === 1'b0 && txd === 1'b1, "R10", "idle after frame",
            {tx_busy, txd}, 1);

      // R3 R4 R2 all formats, parities and stop counts
      for (int f = 0; f < 4; f++)
         for (int o = 0; o < 2; o++)
            for (int s = 0; s < 2; s++) begin
               cfg_fmt = 2'(f);
               cfg_odd = 1'(o);
               cfg_two_stop = 1'(s);
               write(9'(9'h1B3 ^ (f * 71 + o * 29 + s * 13)));
               wait_idle();
            end

      // R7 back-to-back frames with no idle bit
      cfg_fmt = 2'd3; cfg_odd = 1'b1; cfg_two_stop = 1'b1;
      write(9'h03C);
      write(9'h0C1);
      wait (in_frame);
      b2b_mode = 1'b1;
      do @(negedge clk); while (buf_irq !== 1'b1);
      check(txd === 1'b0, "R7", "start bit in the irq cycle", txd, 0);
      write(9'h15A);
      wait_idle();
      b2b_mode = 1'b0;

      // R9 overrun
      cfg_fmt = 2'd0; cfg_two_stop = 1'b0;
      write(9'h011);
      write_raw(9'h022);
      check(ovr_flag === 1'b0, "R9", "no overrun on first buffered word", ovr_flag, 0);
      write(9'h033);
      check(ovr_flag === 1'b1, "R9", "overrun flag set", ovr_flag, 1);
      wait_idle();
      check(ovr_flag === 1'b1, "R9", "overrun flag sticky", ovr_flag, 1);
      @(negedge clk); ovr_clr = 1'b1;
      @(negedge clk); ovr_clr = 1'b0;
      check(ovr_flag === 1'b0, "R9", "overrun flag cleared", ovr_flag, 0);

      // R8 run enable low holds the line
      run_en = 1'b0;
      write(9'h0F0);
      begin
         bit stayed = 1'b1;
         repeat (8 * P) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 1'b0;
         end
         check(stayed && tx_busy === 1'b1, "R8", "line high while disabled",
               {stayed, tx_busy}, 3);
      end
      run_en = 1'b1;
      wait_idle();
      check(exp_q.size() == 0, "R8", "pending frame sent after enable", exp_q.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule